// File: doc/BRIEF.md
# Z80-format external read cycle sequencer

This block sits between a CPU core and the external memory and I/O bus. A read request from the CPU becomes a three-state bus cycle. In the first state the address is driven and a chip select is asserted. In the second state the read strobe and one address-space strobe (memory or I/O) go low. In the third state the bus is held still and the data is captured at its closing clock edge. Each state lasts a configured number of system clocks. An external WAIT line, seen through a synchronizer, can stretch the cycle with wait states between the second and third states.

An external master can claim the bus with an active-low request. The request is honoured only when no read cycle is running. The block then gives an active-low acknowledge and stops driving the address. It keeps decoding chip selects from the address the master drives. Chip selects come from four programmable address windows with fixed priority.

Top module: `z80_bus_seq`

## Requirements
- R1: After reset, rd_n, mreq_n, iorq_n, busack_n and every cs_n bit are high, bus_addr_oe and req_rdy are low.
- R2: During the first state (T1), bus_addr_o carries the request address with bus_addr_oe high, the matching chip select is low, and rd_n, mreq_n and iorq_n are high.
- R3: From the second state (T2) until the cycle ends, rd_n is low. When req_io is 0, mreq_n is low and iorq_n is high. When req_io is 1, iorq_n is low and mreq_n is high.
- R4: T1, T2 and T3 each last cfg_len system clocks, and cfg_len = 0 acts as 1. A read with no wait states therefore reaches req_rdy 3*cfg_len clocks after it starts.
- R5: wait_n passes through a two-flop synchronizer. If the synchronized value is low on the last clock of T2, one-clock wait states follow, with the strobes held, until the synchronized value is seen high; T3 comes next.
- R6: During T3 the address, chip select and strobes do not change. bus_data_i is captured into rd_data at the edge that ends T3, and req_rdy is high for exactly the one following clock.
- R7: With no cycle running, busreq_n low at an edge makes busack_n low from that edge. While busack_n is low, bus_addr_oe is low and rd_n, mreq_n and iorq_n are high.
- R8: A bus request that arrives during a read cycle is not granted until that cycle has finished. busack_n stays high up to and including the req_rdy clock and falls at the next edge.
- R9: While busack_n is low, cs_n is decoded from bus_addr_i.
- R10: busack_n returns high at the first edge at which busreq_n is seen high.
- R11: Window k is matched when cfg_lo[k] <= address <= cfg_hi[k]. Window k drives cs_n[k] low. When several windows match, the lowest index wins. When none match, all cs_n bits stay high, and at most one cs_n bit is ever low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU read request, held until req_rdy |
| req_addr | input | AW | Request address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_rdy | output | 1 | One-clock pulse when read data is captured |
| rd_data | output | DW | Captured read data |
| cfg_len | input | LW | System clocks per bus state (0 acts as 1) |
| cfg_lo | input | NCS*AW | Lower window bounds, window k at bits [k*AW +: AW] |
| cfg_hi | input | NCS*AW | Upper window bounds, same packing |
| bus_addr_o | output | AW | Address driven to the bus |
| bus_addr_oe | output | 1 | Address output enable |
| bus_addr_i | input | AW | Address driven by an external master |
| bus_data_i | input | DW | Read data from the bus |
| rd_n | output | 1 | Active-low read strobe |
| mreq_n | output | 1 | Active-low memory-space strobe |
| iorq_n | output | 1 | Active-low I/O-space strobe |
| wait_n | input | 1 | Active-low wait request, asynchronous |
| busreq_n | input | 1 | Active-low external bus request |
| busack_n | output | 1 | Active-low bus acknowledge |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Two things compete for the same edge: the end of a read cycle and an external bus request. The request has priority in the idle state, so one arriving mid-cycle must wait while the ready pulse is delivered. The bench lowers busreq_n during T2 of a running read. It then checks that busack_n stays high through T2, any wait states, T3 and the req_rdy clock. It also checks that the captured data is correct, that busack_n falls one clock after req_rdy, and that busack_n rises one clock after the request is withdrawn.

// File: rtl/z80_bus_pkg.sv
package z80_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1    = 3'd1,
    ST_T2    = 3'd2,
    ST_TW    = 3'd3,
    ST_T3    = 3'd4,
    ST_GRANT = 3'd5
  } bus_st_e;
endpackage

// File: rtl/z80_wait_sync.sv
module z80_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  output logic wait_s
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= 1'b1;
      wait_s <= 1'b1;
    end else begin
      stage1 <= wait_n;
      wait_s <= stage1;
    end
  end
endmodule

// File: rtl/z80_cs_decode.sv
module z80_cs_decode #(
  parameter int AW  = 16,
  parameter int NCS = 4
) (
  input  logic              enable,
  input  logic [AW-1:0]     addr,
  input  logic [NCS*AW-1:0] lo_flat,
  input  logic [NCS*AW-1:0] hi_flat,
  output logic [NCS-1:0]    cs_n
);
  logic [NCS-1:0] hit;

  function automatic logic in_window(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                                     input logic [AW-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  for (genvar k = 0; k < NCS; k++) begin : g_win
    assign hit[k] = in_window(lo_flat[k*AW +: AW], hi_flat[k*AW +: AW], addr);
  end

  always_comb begin
    cs_n = '1;
    if (enable) begin
      for (int k = NCS - 1; k >= 0; k--) begin
        if (hit[k]) begin
          cs_n    = '1;
          cs_n[k] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/z80_bus_fsm.sv
module z80_bus_fsm
  import z80_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_io,
  input  logic [LW-1:0] cfg_len,
  input  logic          wait_s,
  input  logic          busreq_n,
  input  logic [DW-1:0] bus_data_i,
  output logic [AW-1:0] cyc_addr,
  output logic          in_cycle,
  output logic          granted,
  output logic          strobe_on,
  output logic          cyc_io,
  output logic          t3_active,
  output logic          req_rdy,
  output logic [DW-1:0] rd_data
);
  bus_st_e       state;
  logic [LW-1:0] cnt;
  logic          st_end;

  function automatic logic [LW-1:0] last_tick(input logic [LW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign st_end = (cnt == last_tick(cfg_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cyc_addr <= '0;
      cyc_io   <= 1'b0;
      req_rdy  <= 1'b0;
      rd_data  <= '0;
    end else begin
      req_rdy <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!busreq_n) begin
            state <= ST_GRANT;
          end else if (req_valid && !req_rdy) begin
            state    <= ST_T1;
            cyc_addr <= req_addr;
            cyc_io   <= req_io;
          end
        end
        ST_T1: begin
          if (st_end) begin
            state <= ST_T2;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_T2: begin
          if (st_end) begin
            cnt   <= '0;
            state <= wait_s ? ST_T3 : ST_TW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TW: begin
          if (wait_s) state <= ST_T3;
        end
        ST_T3: begin
          if (st_end) begin
            rd_data <= bus_data_i;
            req_rdy <= 1'b1;
            cnt     <= '0;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GRANT: begin
          if (busreq_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_cycle  = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
  assign strobe_on = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
  assign granted   = (state == ST_GRANT);
  assign t3_active = (state == ST_T3);
endmodule

// File: rtl/z80_bus_seq.sv
module z80_bus_seq #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int LW  = 4,
  parameter int NCS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_io,
  output logic              req_rdy,
  output logic [DW-1:0]     rd_data,
  input  logic [LW-1:0]     cfg_len,
  input  logic [NCS*AW-1:0] cfg_lo,
  input  logic [NCS*AW-1:0] cfg_hi,
  output logic [AW-1:0]     bus_addr_o,
  output logic              bus_addr_oe,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_data_i,
  output logic              rd_n,
  output logic              mreq_n,
  output logic              iorq_n,
  input  logic              wait_n,
  input  logic              busreq_n,
  output logic              busack_n,
  output logic [NCS-1:0]    cs_n
);
  logic          wait_s;
  logic          in_cycle;
  logic          granted;
  logic          strobe_on;
  logic          cyc_io;
  logic          t3_active;
  logic [AW-1:0] cyc_addr;
  logic [AW-1:0] dec_addr;

  z80_wait_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .wait_n (wait_n),
    .wait_s (wait_s)
  );

  z80_bus_fsm #(.AW(AW), .DW(DW), .LW(LW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_io     (req_io),
    .cfg_len    (cfg_len),
    .wait_s     (wait_s),
    .busreq_n   (busreq_n),
    .bus_data_i (bus_data_i),
    .cyc_addr   (cyc_addr),
    .in_cycle   (in_cycle),
    .granted    (granted),
    .strobe_on  (strobe_on),
    .cyc_io     (cyc_io),
    .t3_active  (t3_active),
    .req_rdy    (req_rdy),
    .rd_data    (rd_data)
  );

  assign dec_addr = granted ? bus_addr_i : cyc_addr;

  z80_cs_decode #(.AW(AW), .NCS(NCS)) u_dec (
    .enable  (in_cycle | granted),
    .addr    (dec_addr),
    .lo_flat (cfg_lo),
    .hi_flat (cfg_hi),
    .cs_n    (cs_n)
  );

  assign bus_addr_o  = cyc_addr;
  assign bus_addr_oe = in_cycle;
  assign rd_n        = ~strobe_on;
  assign mreq_n      = ~(strobe_on & ~cyc_io);
  assign iorq_n      = ~(strobe_on & cyc_io);
  assign busack_n    = ~granted;
endmodule

// File: rtl/z80_bus_chk.sv
module z80_bus_chk #(
  parameter int AW  = 16,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_n,
  input logic           mreq_n,
  input logic           iorq_n,
  input logic           busack_n,
  input logic           bus_addr_oe,
  input logic           req_rdy,
  input logic [NCS-1:0] cs_n,
  input logic [AW-1:0]  bus_addr_o,
  input logic           t3_active
);
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> (rd_n && mreq_n && iorq_n && !bus_addr_oe)); // R7
  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (mreq_n != iorq_n)); // R3
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R11
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdy |=> !req_rdy); // R6
  AST_RDY_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdy |-> $past(t3_active)); // R6
  AST_T3_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (t3_active && $past(t3_active)) |-> ($stable(bus_addr_o) && $stable(rd_n) && $stable(cs_n)
                                         && $stable(mreq_n) && $stable(iorq_n))); // R6
  AST_GRANT_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busack_n) |-> $past(rd_n && !bus_addr_oe)); // R8
endmodule

bind z80_bus_seq z80_bus_chk #(.AW(AW), .NCS(NCS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_n        (rd_n),
  .mreq_n      (mreq_n),
  .iorq_n      (iorq_n),
  .busack_n    (busack_n),
  .bus_addr_oe (bus_addr_oe),
  .req_rdy     (req_rdy),
  .cs_n        (cs_n),
  .bus_addr_o  (bus_addr_o),
  .t3_active   (t3_active)
);

// File: tb/z80_bus_seq_tb.sv
module z80_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 8, LW = 4, NCS = 4;

  // vector: {addr[29:14], io[13], len[12:9], data[8:1], use_wait[0]}
  localparam logic [29:0] VEC [6] = '{
    {16'h0800, 1'b0, 4'd1, 8'h5A, 1'b0},
    {16'h2000, 1'b1, 4'd2, 8'hA5, 1'b0},
    {16'h9000, 1'b0, 4'd3, 8'h3C, 1'b1},
    {16'hC100, 1'b1, 4'd1, 8'h81, 1'b1},
    {16'hF000, 1'b0, 4'd2, 8'h00, 1'b0},
    {16'h0100, 1'b0, 4'd0, 8'hFF, 1'b0}
  };
  localparam logic [AW-1:0] WLO [NCS] = '{16'h0000, 16'h0800, 16'h8000, 16'hC000};
  localparam logic [AW-1:0] WHI [NCS] = '{16'h0FFF, 16'h3FFF, 16'hBFFF, 16'hEFFF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0, wait_n = 1'b1, busreq_n = 1'b1;
  logic [AW-1:0] req_addr = '0, bus_addr_i = '0;
  logic [DW-1:0] bus_data_i = '0;
  logic [LW-1:0] cfg_len = 4'd1;
  logic [NCS*AW-1:0] cfg_lo, cfg_hi;
  logic req_rdy, bus_addr_oe, rd_n, mreq_n, iorq_n, busack_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr_o;
  logic [NCS-1:0] cs_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCS; k++) begin
      cfg_lo[k*AW +: AW] = WLO[k];
      cfg_hi[k*AW +: AW] = WHI[k];
    end
  end

  z80_bus_seq #(.AW(AW), .DW(DW), .LW(LW), .NCS(NCS)) dut_i (.*);

  function automatic logic [NCS-1:0] exp_cs(input logic [AW-1:0] a);
    logic [NCS-1:0] r = '1;
    for (int k = 0; k < NCS; k++)
      if (r == '1 && a >= WLO[k] && a <= WHI[k]) r[k] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_read(input logic [29:0] v, input bit mid_req);
    logic [AW-1:0] a  = v[29:14];
    logic          io = v[13];
    logic [3:0]    n  = v[12:9];
    logic [7:0]    d  = v[8:1];
    bit            uw = v[0];
    int ne = (n == 0) ? 1 : int'(n);
    int w  = uw ? 3 : 0;
    int last = 3*ne + w + 1;
    logic [NCS-1:0] ecs = exp_cs(a);
    @(negedge clk);
    cfg_len = n; bus_data_i = d; req_addr = a; req_io = io; wait_n = !uw;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      if (uw && i == 2*ne + 1) wait_n = 1'b1;
      if (mid_req && i == ne + 1) busreq_n = 1'b0;
      if (i <= ne) begin
        chk(rd_n && mreq_n && iorq_n && bus_addr_oe && bus_addr_o == a, "R2 T1 drive",
            {rd_n, mreq_n, iorq_n, bus_addr_oe, bus_addr_o}, {4'b1111, a});
        chk(cs_n == ecs, "R11 cs in T1", cs_n, ecs);
      end else if (i < last) begin
        chk(!rd_n && mreq_n == io && iorq_n == !io, "R3 strobes",
            {rd_n, mreq_n, iorq_n}, {1'b0, io, !io});
        chk(cs_n == ecs && bus_addr_o == a, "R6 hold", {cs_n, bus_addr_o}, {ecs, a});
        chk(!req_rdy, "R4 R5 no early ready", req_rdy, 0);
      end else begin
        chk(req_rdy && rd_data == d, "R6 capture", {req_rdy, rd_data}, {1'b1, d});
        chk(rd_n && !bus_addr_oe, "R4 cycle length", {rd_n, bus_addr_oe}, 2'b10);
        req_valid = 1'b0;
      end
      if (mid_req) chk(busack_n, "R8 no grant mid-cycle", busack_n, 1);
    end
    if (mid_req) begin
      @(negedge clk);
      chk(!busack_n && !req_rdy, "R8 grant after cycle", {busack_n, req_rdy}, 0);
      busreq_n = 1'b1;
      @(negedge clk);
      chk(busack_n, "R10 release", busack_n, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_n && mreq_n && iorq_n && busack_n && cs_n == '1 && !bus_addr_oe && !req_rdy,
        "R1 reset", {rd_n, mreq_n, iorq_n, busack_n, cs_n, bus_addr_oe, req_rdy}, 10'h3FC);
    rst_n = 1'b1;
    foreach (VEC[j]) run_read(VEC[j], 1'b0);
    // R5/R8: bus request raised during a stretched read
    run_read({16'h9000, 1'b1, 4'd2, 8'hC3, 1'b1}, 1'b1);
    // R7/R9: grant from idle, decode external master address
    @(negedge clk);
    bus_addr_i = 16'h9000; busreq_n = 1'b0;
    @(negedge clk);
    chk(!busack_n && !bus_addr_oe && rd_n && mreq_n && iorq_n, "R7 grant quiet",
        {busack_n, bus_addr_oe, rd_n, mreq_n, iorq_n}, 5'b00111);
    chk(cs_n == 4'b1011, "R9 cs from master", cs_n, 4'b1011);
    bus_addr_i = 16'h0900; #1;
    chk(cs_n == 4'b1110, "R9 R11 priority", cs_n, 4'b1110);
    bus_addr_i = 16'hF800; #1;
    chk(cs_n == 4'b1111, "R11 no match", cs_n, 4'b1111);
    @(negedge clk);
    busreq_n = 1'b1;
    @(negedge clk);
    chk(busack_n && cs_n == 4'b1111, "R10 release idle", {busack_n, cs_n}, 5'b11111);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule